// File: doc/BRIEF.md
# Four-Input ADC Scan Sequencer

This block is the digital controller that sits in front of a successive-approximation conversion engine serving four analog inputs. It decides which input is converted next, hands the engine a channel number together with a one-cycle start request, waits for the engine's done pulse, and writes the 8-bit result into one of four result registers. A sticky interrupt flag is raised according to the scan mode, and an enable input gates the flag onto the interrupt line.

Two scan modes exist. In dual-channel mode two chosen inputs, A and B, are converted alternately into slots 0 to 3 (A, B, A, B). The flag is raised once per completed set of four, and the scan then restarts at slot 0 on its own. In single-step mode a four-bit mask picks any subset of inputs. Each trigger converts the next selected input, taken in ascending index order with wrap-around. The result goes to the slot with the same index as the input, and the flag is raised after every conversion. Triggers come either from a software go strobe or from a timer overflow pulse, and either source works with either scan mode.

The controller has three states. S_IDLE waits for a trigger. S_ISSUE holds a pending start until the engine is free. S_CONV waits for the done pulse. The transitions are: S_IDLE to S_ISSUE on an accepted trigger; S_ISSUE to S_CONV when the start is issued; S_ISSUE to S_IDLE when the run enable is dropped; S_CONV to S_ISSUE after a dual-mode result while running; S_CONV to S_IDLE after a single-step result, or after any result once the run enable is low.

Top module: `adc_seq_ctrl`

## Requirements
- R1: In dual mode (scan_mode=0) the k-th conversion of a set uses channel chan_a for k=0,2 and chan_b for k=1,3, and its result is written to result slot k (res_bus bits 8k+7..8k).
- R2: In dual mode irq_flag is raised only by the completion of the slot 3 conversion; the first three conversions of a set leave it low.
- R3: In dual mode, after slot 3 is written and run_en is still high, the next conversion starts at slot 0 with channel chan_a, with no further trigger.
- R4: In single-step mode (scan_mode=1) each trigger converts the next channel whose step_mask bit is set, searching upward from the last converted channel and wrapping from 3 to 0, and the result is written to the slot equal to that channel index.
- R5: In single-step mode irq_flag is raised after every conversion, and no further conversion starts until the next trigger.
- R6: With trig_sel=0 only go_pulse triggers and with trig_sel=1 only tmr_ovf triggers; a trigger is accepted only while the sequencer is idle, so pulses during a conversion are ignored.
- R7: In single-step mode a trigger with step_mask all zero starts no conversion.
- R8: irq_flag stays set until an irq_clr strobe; irq equals irq_flag gated by irq_en, and irq_en does not alter irq_flag.
- R9: When a conversion that raises the flag completes in the same cycle as an irq_clr strobe, irq_flag ends up set.
- R10: Lowering run_en lets the conversion in progress finish and store its result, then no further start occurs; the next run begins again at slot 0 in dual mode and from the lowest selected channel in single-step mode.
- R11: After reset all result slots read zero, irq_flag is low and conv_start is low; conv_start is only asserted while conv_busy is low and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Sequencer enable; low stops after the current conversion |
| scan_mode | input | 1 | 0 dual-channel continuous, 1 single-step |
| trig_sel | input | 1 | 0 software go strobe, 1 timer overflow |
| go_pulse | input | 1 | Software start strobe |
| tmr_ovf | input | 1 | Timer overflow pulse |
| chan_a | input | 2 | First channel of dual mode |
| chan_b | input | 2 | Second channel of dual mode |
| step_mask | input | 4 | Channel selection for single-step mode |
| irq_en | input | 1 | Interrupt output enable |
| irq_clr | input | 1 | Clears the interrupt flag |
| conv_start | output | 1 | One-cycle start request to the engine |
| conv_chan | output | 2 | Channel for the requested conversion |
| conv_busy | input | 1 | Engine is converting |
| conv_done | input | 1 | One-cycle pulse: result valid |
| conv_data | input | 8 | Conversion result |
| res_bus | output | 32 | Result slots, slot k in bits 8k+7..8k |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Gated interrupt |

## Verification
Two events can fall in the same cycle: the done pulse that sets the interrupt flag, and a software clear of that flag. The bench waits until the engine model's done pulse is visible and raises irq_clr for exactly that cycle. It then expects the flag to read set afterwards. A second collision is a timer pulse arriving while a conversion is busy: the bench fires such pulses and judges them by counting start requests, which must rise by exactly one.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_CONV  = 2'd2
    } seq_state_t;

    localparam logic SCAN_DUAL  = 1'b0;
    localparam logic SCAN_STEP  = 1'b1;
    localparam logic TRIG_SOFT  = 1'b0;
    localparam logic TRIG_TIMER = 1'b1;

endpackage

// File: rtl/adc_seq_chsel.sv
// Picks the next selected channel strictly above the last one, wrapping.
module adc_seq_chsel #(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] mask_i,
    input  logic [CW-1:0]  last_i,
    output logic [CW-1:0]  next_o,
    output logic           any_o
);

    always_comb begin
        logic found;
        int   idx;
        found  = 1'b0;
        next_o = '0;
        any_o  = |mask_i;
        for (int off = 1; off <= NCH; off++) begin
            idx = (int'(last_i) + off) % NCH;
            if (!found && mask_i[idx]) begin
                next_o = CW'(idx);
                found  = 1'b1;
            end
        end
    end

    // R4: the chosen channel is always one that the mask selects
    a_r4_pick_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> mask_i[next_o]);

endmodule

// File: rtl/adc_seq_slots.sv
// Result slot registers.
module adc_seq_slots #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int CW  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [CW-1:0]      idx_i,
    input  logic [DW-1:0]      data_i,
    output logic [NCH*DW-1:0]  res_o
);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_o[g*DW +: DW] <= '0;
                end else if (wr_i && idx_i == CW'(g)) begin
                    res_o[g*DW +: DW] <= data_i;
                end
            end
        end
    endgenerate

    // R1: slots change only on a result write
    a_r1_slots_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(res_o));

endmodule

// File: rtl/adc_seq_irq.sv
// Sticky interrupt flag with set priority over clear.
module adc_seq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    always_comb irq_o = flag_o & en_i;

    // R9: a set in the clear cycle still leaves the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R8: flag holds until cleared
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R8: clear without set drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int DW  = 8,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              scan_mode,
    input  logic              trig_sel,
    input  logic              go_pulse,
    input  logic              tmr_ovf,
    input  logic [CW-1:0]     chan_a,
    input  logic [CW-1:0]     chan_b,
    input  logic [NCH-1:0]    step_mask,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              conv_start,
    output logic [CW-1:0]     conv_chan,
    input  logic              conv_busy,
    input  logic              conv_done,
    input  logic [DW-1:0]     conv_data,
    output logic [NCH*DW-1:0] res_bus,
    output logic              irq_flag,
    output logic              irq
);

    localparam logic [CW-1:0] TOP_IDX = CW'(NCH - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] slot_q, slot_d;
    logic [CW-1:0] chan_q, chan_d;
    logic [CW-1:0] last_q, last_d;
    logic          wr_en;
    logic [CW-1:0] wr_idx;
    logic          flag_set;
    logic          trig_hit;
    logic [CW-1:0] step_next;
    logic          step_any;

    adc_seq_chsel #(.NCH(NCH), .CW(CW)) u_chsel (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_i (step_mask),
        .last_i (last_q),
        .next_o (step_next),
        .any_o  (step_any)
    );

    adc_seq_slots #(.NCH(NCH), .DW(DW), .CW(CW)) u_slots (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_en),
        .idx_i  (wr_idx),
        .data_i (conv_data),
        .res_o  (res_bus)
    );

    adc_seq_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (irq_clr),
        .en_i   (irq_en),
        .flag_o (irq_flag),
        .irq_o  (irq)
    );

    always_comb begin
        trig_hit = run_en && ((trig_sel == TRIG_TIMER) ? tmr_ovf : go_pulse);
    end

    // next-state and datapath control
    always_comb begin
        state_d  = state_q;
        slot_d   = slot_q;
        chan_d   = chan_q;
        last_d   = last_q;
        wr_en    = 1'b0;
        wr_idx   = slot_q;
        flag_set = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (!run_en) begin
                    slot_d = '0;
                    last_d = TOP_IDX;
                end else if (trig_hit) begin
                    if (scan_mode == SCAN_DUAL) begin
                        chan_d  = slot_q[0] ? chan_b : chan_a;
                        state_d = S_ISSUE;
                    end else if (step_any) begin
                        chan_d  = step_next;
                        state_d = S_ISSUE;
                    end
                end
            end
            S_ISSUE: begin
                if (!run_en) begin
                    state_d = S_IDLE;
                end else if (!conv_busy) begin
                    state_d = S_CONV;
                end
            end
            S_CONV: begin
                if (conv_done) begin
                    wr_en = 1'b1;
                    if (scan_mode == SCAN_DUAL) begin
                        wr_idx   = slot_q;
                        flag_set = (slot_q == TOP_IDX);
                        slot_d   = (slot_q == TOP_IDX) ? '0 : slot_q + 1'b1;
                        if (run_en) begin
                            chan_d  = slot_d[0] ? chan_b : chan_a;
                            state_d = S_ISSUE;
                        end else begin
                            state_d = S_IDLE;
                        end
                    end else begin
                        wr_idx   = chan_q;
                        flag_set = 1'b1;
                        last_d   = chan_q;
                        state_d  = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            slot_q  <= '0;
            chan_q  <= '0;
            last_q  <= TOP_IDX;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            chan_q  <= chan_d;
            last_q  <= last_d;
        end
    end

    // outputs
    always_comb begin
        conv_start = (state_q == S_ISSUE) && run_en && !conv_busy;
        conv_chan  = chan_q;
    end

    // R11: a start request lasts a single cycle
    a_r11_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R10: nothing starts while stopped
    a_r10_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !conv_start);

    // R2: dual mode results other than slot 3 leave a clear flag clear
    a_r2_flag_only_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CONV && conv_done && scan_mode == SCAN_DUAL &&
         slot_q != TOP_IDX && !irq_flag) |=> !irq_flag);

    // R5: single-step pauses after each result
    a_r5_step_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CONV && conv_done && scan_mode == SCAN_STEP) |=> state_q == S_IDLE);

endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;

    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int CW  = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, run_en, scan_mode, trig_sel, go_pulse, tmr_ovf;
    logic [CW-1:0] chan_a, chan_b, conv_chan;
    logic [NCH-1:0] step_mask;
    logic irq_en, irq_clr, conv_start, conv_busy, conv_done, irq_flag, irq;
    logic [DW-1:0] conv_data;
    logic [NCH*DW-1:0] res_bus;

    adc_seq_ctrl #(.NCH(NCH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .scan_mode(scan_mode),
        .trig_sel(trig_sel), .go_pulse(go_pulse), .tmr_ovf(tmr_ovf),
        .chan_a(chan_a), .chan_b(chan_b), .step_mask(step_mask),
        .irq_en(irq_en), .irq_clr(irq_clr), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_busy(conv_busy), .conv_done(conv_done),
        .conv_data(conv_data), .res_bus(res_bus), .irq_flag(irq_flag), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    int start_cnt = 0;
    int done_cnt = 0;
    int eng_cnt = 0;
    bit ended = 1'b0;
    logic [CW-1:0] log_ch [256];
    logic [DW-1:0] log_dat [256];

    // conversion engine model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_busy <= 1'b0;
            conv_done <= 1'b0;
            conv_data <= '0;
            eng_cnt   <= 0;
        end else begin
            conv_done <= 1'b0;
            if (eng_cnt != 0) begin
                eng_cnt <= eng_cnt - 1;
                if (eng_cnt == 1) begin
                    conv_done <= 1'b1;
                    conv_busy <= 1'b0;
                    conv_data <= DW'($urandom);
                end
            end else if (conv_start) begin
                conv_busy <= 1'b1;
                eng_cnt   <= 3 + int'($urandom % 4);
            end
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_start) begin
                log_ch[start_cnt % 256] = conv_chan;
                start_cnt++;
            end
            if (conv_done) begin
                log_dat[done_cnt % 256] = conv_data;
                done_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic int slot(input int k);
        return int'(res_bus[k*DW +: DW]);
    endfunction

    function automatic int nxt_sel(input int last, input int mask);
        for (int off = 1; off <= NCH; off++) begin
            int idx = (last + off) % NCH;
            if (mask[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic pulse_go();
        @(negedge clk); go_pulse = 1'b1;
        @(negedge clk); go_pulse = 1'b0;
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic wait_done(input int n);
        while (done_cnt < n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic stop_run(input string tag);
        int s;
        while (!conv_busy) @(negedge clk);
        run_en = 1'b0;
        s = start_cnt;
        wait_done(s);
        repeat (12) @(negedge clk);
        chk(tag, start_cnt, s);
    endtask

    task automatic restart();
        @(negedge clk); run_en = 1'b0;
        repeat (2) @(negedge clk);
        run_en = 1'b1;
    endtask

    task automatic dual_set(input int base, input int a, input int b, input string tag);
        wait_done(base + 3);
        chk({tag, " R2 no flag after three"}, int'(irq_flag), 0);
        wait_done(base + 4);
        chk({tag, " R2 flag after four"}, int'(irq_flag), 1);
        for (int k = 0; k < 4; k++) begin
            chk({tag, " R1 channel order"}, int'(log_ch[(base + k) % 256]), (k % 2 == 0) ? a : b);
            chk({tag, " R1 slot contents"}, slot(k), int'(log_dat[(base + k) % 256]));
        end
    endtask

    initial begin
        int s, last, exp, mask, a, b;
        void'($urandom(32'd2024));
        rst_n = 1'b0; run_en = 1'b0; scan_mode = 1'b0; trig_sel = 1'b0;
        go_pulse = 1'b0; tmr_ovf = 1'b0; chan_a = 2'd1; chan_b = 2'd2;
        step_mask = '0; irq_en = 1'b1; irq_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset results", int'(res_bus != 0), 0);
        chk("R11 reset flag", int'(irq_flag), 0);
        chk("R11 reset start", int'(conv_start), 0);

        // dual mode, software trigger
        run_en = 1'b1;
        s = start_cnt;
        repeat (4) @(negedge clk);
        chk("R6 enable alone starts nothing", start_cnt, s);
        pulse_tmr();
        repeat (10) @(negedge clk);
        chk("R6 timer ignored in soft mode", start_cnt, s);
        pulse_go();
        dual_set(s, 1, 2, "dual1");
        pulse_clr();
        chk("R8 clear drops flag", int'(irq_flag), 0);
        while (start_cnt < s + 5) @(negedge clk);
        chk("R3 continues at slot 0 channel", int'(log_ch[(s + 4) % 256]), 1);
        dual_set(s + 4, 1, 2, "dual2 R3");
        stop_run("R10 dual stop");
        pulse_clr();

        // restart must begin at slot 0
        s = start_cnt;
        run_en = 1'b1;
        pulse_go();
        wait_done(s + 1);
        chk("R10 restart channel", int'(log_ch[s % 256]), 1);
        chk("R10 restart slot 0", slot(0), int'(log_dat[s % 256]));
        stop_run("R10 dual stop again");
        pulse_clr();

        // single-step, timer trigger, mask 1010
        scan_mode = 1'b1; trig_sel = 1'b1; step_mask = 4'b1010;
        restart();
        s = start_cnt;
        pulse_go();
        repeat (10) @(negedge clk);
        chk("R6 go ignored in timer mode", start_cnt, s);
        pulse_tmr();
        while (!conv_busy) @(negedge clk);
        pulse_tmr();
        pulse_tmr();
        wait_done(s + 1);
        repeat (12) @(negedge clk);
        chk("R6 busy pulses ignored", start_cnt, s + 1);
        chk("R4 first selected", int'(log_ch[s % 256]), 1);
        chk("R4 slot by channel", slot(1), int'(log_dat[s % 256]));
        chk("R5 flag per step", int'(irq_flag), 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R8 gated irq low", int'(irq), 0);
        chk("R8 flag kept", int'(irq_flag), 1);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R8 irq follows flag", int'(irq), 1);
        pulse_clr();

        // collision: flag set in the clear cycle
        s = start_cnt;
        pulse_tmr();
        do @(negedge clk); while (!conv_done);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        @(negedge clk);
        chk("R9 set beats clear", int'(irq_flag), 1);
        chk("R4 second selected", int'(log_ch[s % 256]), 3);
        pulse_clr();
        s = start_cnt;
        pulse_tmr();
        wait_done(s + 1);
        chk("R4 wrap to lowest", int'(log_ch[s % 256]), 1);
        pulse_clr();

        // stop resets step position
        restart();
        s = start_cnt;
        pulse_tmr();
        wait_done(s + 1);
        chk("R10 step position reset", int'(log_ch[s % 256]), 1);
        pulse_clr();

        // empty mask
        step_mask = '0;
        s = start_cnt;
        pulse_tmr();
        repeat (12) @(negedge clk);
        chk("R7 empty mask no start", start_cnt, s);
        chk("R7 no flag", int'(irq_flag), 0);

        // random single-step, software trigger
        trig_sel = 1'b0;
        restart();
        last = 3;
        for (int i = 0; i < 30; i++) begin
            mask = 1 + int'($urandom % 15);
            step_mask = NCH'(mask);
            exp = nxt_sel(last, mask);
            s = start_cnt;
            pulse_go();
            wait_done(s + 1);
            repeat (6) @(negedge clk);
            chk("R4 random pick", int'(log_ch[s % 256]), exp);
            chk("R4 random slot", slot(exp), int'(log_dat[s % 256]));
            chk("R5 random single start", start_cnt, s + 1);
            irq_en = 1'($urandom % 2);
            @(negedge clk);
            chk("R8 random gating", int'(irq), int'(irq_en));
            pulse_clr();
            last = exp;
        end
        irq_en = 1'b1;

        // random dual rounds, timer trigger
        scan_mode = 1'b0; trig_sel = 1'b1;
        for (int r = 0; r < 4; r++) begin
            a = int'($urandom % 4);
            b = int'($urandom % 4);
            chan_a = CW'(a); chan_b = CW'(b);
            restart();
            s = start_cnt;
            pulse_tmr();
            dual_set(s, a, b, "rand dual");
            stop_run("R10 random stop");
            pulse_clr();
        end

        finish_up();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R11 actual=timeout expected=completion");
        finish_up();
    end

endmodule